// File: doc/BRIEF.md
# Clock Synthesizer Control Register and Lock Sequencer

This block holds the 16-bit software-visible control word of an on-chip clock synthesizer and runs the digital sequencing around it. It turns the raw multiplier and divider codes into integer M and N values. It drives the synthesizer power enable and the analog trim fields straight from the stored word. The synthesized internal clock runs at the reference frequency times M/(2N), which is half the oscillator frequency.

Each time the synthesizer is powered up, the block counts a lock-in interval of `LOCK_CYCLES` reference cycles. The oscillator output is not trusted during that interval. A lock flag rises when the interval ends. Turning the power off, or changing M or N while powered, clears the flag and restarts the count.

The internal clock select is a registered signal. It selects the synthesized clock only when software has asked for it and the lock flag is set. Until then the reference input stays in use. A second address returns the lock flag and a sticky flag that records an out-of-range multiplier.

Top module: `pll_ctl_seq`

## Requirements
- R1: After synchronous reset the control word reads 0x0000, and power enable, lock flag, clock select and configuration-error flag are all 0.
- R2: A write to the control address (0) stores all 16 bits. A read at address 0 returns the stored word combinationally in the cycle after the write edge.
- R3: The divider output is N = code+2 for a 3-bit code at bits 7:5 of 000..110, and N = 1 for code 111.
- R4: The multiplier output is M = code+2 for the 5-bit code at bits 4:0.
- R5: After the write edge that raises power enable (bit 15), the lock flag stays low for LOCK_CYCLES-1 more edges and goes high on the LOCK_CYCLES-th edge after the write edge.
- R6: A write that clears power enable drops the lock flag at that write edge. A later power-up starts a full new lock-in interval.
- R7: A control write that changes the M or N code while power is on drops the lock flag at the write edge and restarts the interval. A write that changes only other fields leaves the lock flag unchanged.
- R8: The clock select is high exactly when source select (bit 14) and the lock flag are both high. It changes at the same edge as the lock flag, so setting source select before lock keeps the reference selected.
- R9: A control write with a multiplier code above 22 (M > 24) sets the configuration-error flag from the next edge. The flag stays set until reset, and the written word is still stored.
- R10: The status address (1) reads lock flag in bit 0 and configuration error in bit 1, with all other bits 0. Writes to the status address leave the control word unchanged.
- R11: The charge-pump bit (13), supply-range bit (12) and loop-filter field (11:8) drive their outputs directly from the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (0 control, 1 status) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| synth_pwr | output | 1 | Synthesizer power enable |
| pump_hi | output | 1 | Charge-pump current setting |
| supply_hi | output | 1 | Supply-range setting |
| loop_filt | output | 4 | Loop-filter setting |
| mult_m | output | 6 | Decoded multiplier M |
| div_n | output | 4 | Decoded divider N |
| pll_locked | output | 1 | Lock-in interval complete |
| clk_sel_synth | output | 1 | 1 selects the synthesized clock, 0 the reference |
| cfg_err | output | 1 | Sticky multiplier-range error |

## Verification
The stored word, the decoded M and N, the trim outputs and the error flag are due in the cycle after the write edge. A read is due in the same cycle as its address. The lock flag and the clock select are due exactly LOCK_CYCLES edges after the write edge that starts an interval, and each is also checked one cycle earlier to confirm it is still low. Every stimulus task records the cycle in which each result falls due. The monitor compares only in that cycle, on the falling clock edge, so no check samples at an active edge.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int REG_W = 16;
    localparam int M_W   = 6;
    localparam int N_W   = 4;
    localparam int M_MAX = 24;

    typedef struct packed {
        logic       pwr_on;
        logic       use_synth;
        logic       pump_hi;
        logic       supply_hi;
        logic [3:0] filt;
        logic [2:0] ncode;
        logic [4:0] mcode;
    } pll_cfg_t;

    typedef struct packed {
        logic cfg_bad;
        logic locked;
    } pll_stat_t;

    typedef enum logic [1:0] {
        AK_CTRL = 2'd0,
        AK_STAT = 2'd1,
        AK_NONE = 2'd2
    } addr_kind_t;

    function automatic logic [N_W-1:0] decode_n(input logic [2:0] code);
        if (code == 3'b111) return N_W'(1);
        return N_W'(code) + N_W'(2);
    endfunction

    function automatic logic [M_W-1:0] decode_m(input logic [4:0] code);
        return M_W'(code) + M_W'(2);
    endfunction

    function automatic logic m_illegal(input logic [4:0] code);
        return int'(decode_m(code)) > M_MAX;
    endfunction

endpackage

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
    import pllseq_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              locked,
    output pll_cfg_t          cfg_q,
    output pll_cfg_t          cfg_d,
    output logic              restart,
    output logic              cfg_bad,
    output logic [REG_W-1:0]  rd_data
);

    addr_kind_t kind;
    pll_cfg_t   wcfg;
    pll_stat_t  stat;
    logic       ctrl_wr;

    always_comb begin
        if (addr == ADDR_W'(CTRL_ADDR))      kind = AK_CTRL;
        else if (addr == ADDR_W'(STAT_ADDR)) kind = AK_STAT;
        else                                 kind = AK_NONE;
    end

    assign wcfg    = pll_cfg_t'(wr_data);
    assign ctrl_wr = wr_en && (kind == AK_CTRL);
    assign cfg_d   = ctrl_wr ? wcfg : cfg_q;

    // Restart the lock-in interval on power-down or on a new M/N setting.
    assign restart = ctrl_wr && (!wcfg.pwr_on ||
                                 (wcfg.mcode != cfg_q.mcode) ||
                                 (wcfg.ncode != cfg_q.ncode));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cfg_bad <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            if (ctrl_wr && m_illegal(wcfg.mcode)) cfg_bad <= 1'b1;
        end
    end

    assign stat.cfg_bad = cfg_bad;
    assign stat.locked  = locked;

    always_comb begin
        unique case (kind)
            AK_CTRL: rd_data = REG_W'(cfg_q);
            AK_STAT: rd_data = REG_W'(stat);
            default: rd_data = '0;
        endcase
    end

    assert_stat_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == AK_STAT) |=> $stable(cfg_q));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |=> cfg_bad);

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LOCK_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_on_q,
    input  logic restart,
    output logic lock_d,
    output logic lock_q
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (restart || !pwr_on_q) cnt_d = '0;
        else if (cnt_q == LIMIT)  cnt_d = cnt_q;
        else                      cnt_d = cnt_q + CNT_W'(1);
    end

    assign lock_d = (cnt_d == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lock_q <= lock_d;
        end
    end

    assert_no_lock_unpowered_R6: assert property (@(posedge clk) disable iff (rst)
        !pwr_on_q |-> !lock_q);

    assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    assert_restart_drops_lock_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !lock_q);

endmodule

// File: rtl/pll_src_sel.sv
module pll_src_sel (
    input  logic clk,
    input  logic rst,
    input  logic use_synth_d,
    input  logic lock_d,
    output logic sel_q
);

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= use_synth_d && lock_d;
    end

endmodule

// File: rtl/pll_ctl_seq.sv
module pll_ctl_seq
    import pllseq_pkg::*;
#(
    parameter int LOCK_CYCLES = 32,
    parameter int ADDR_W      = 2,
    parameter int CTRL_ADDR   = 0,
    parameter int STAT_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    output logic              synth_pwr,
    output logic              pump_hi,
    output logic              supply_hi,
    output logic [3:0]        loop_filt,
    output logic [5:0]        mult_m,
    output logic [3:0]        div_n,
    output logic              pll_locked,
    output logic              clk_sel_synth,
    output logic              cfg_err
);

    pll_cfg_t cfg_q, cfg_d;
    logic     restart, lock_d, lock_q, sel_q, bad;

    pll_cfg_reg #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .locked (lock_q),
        .cfg_q  (cfg_q),
        .cfg_d  (cfg_d),
        .restart(restart),
        .cfg_bad(bad),
        .rd_data(rd_data)
    );

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .pwr_on_q(cfg_q.pwr_on),
        .restart (restart),
        .lock_d  (lock_d),
        .lock_q  (lock_q)
    );

    pll_src_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .use_synth_d(cfg_d.use_synth),
        .lock_d     (lock_d),
        .sel_q      (sel_q)
    );

    assign synth_pwr     = cfg_q.pwr_on;
    assign pump_hi       = cfg_q.pump_hi;
    assign supply_hi     = cfg_q.supply_hi;
    assign loop_filt     = cfg_q.filt;
    assign mult_m        = decode_m(cfg_q.mcode);
    assign div_n         = decode_n(cfg_q.ncode);
    assign pll_locked    = lock_q;
    assign clk_sel_synth = sel_q;
    assign cfg_err       = bad;

    assert_sel_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
        clk_sel_synth |-> (pll_locked && cfg_q.use_synth));

    assert_lock_rise_powered_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_locked) |-> $past(synth_pwr) && synth_pwr);

    assert_n_range_R3: assert property (@(posedge clk) disable iff (rst)
        (div_n >= 4'd1) && (div_n <= 4'd8));

endmodule

// File: tb/pll_ctl_seq_tb.sv
module pll_ctl_seq_tb;

    localparam int L = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        synth_pwr, pump_hi, supply_hi, pll_locked, clk_sel_synth, cfg_err;
    logic [3:0]  loop_filt, div_n;
    logic [5:0]  mult_m;

    pll_ctl_seq #(.LOCK_CYCLES(L)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .synth_pwr(synth_pwr), .pump_hi(pump_hi),
        .supply_hi(supply_hi), .loop_filt(loop_filt), .mult_m(mult_m),
        .div_n(div_n), .pll_locked(pll_locked), .clk_sel_synth(clk_sel_synth),
        .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    typedef enum int {K_RD, K_M, K_N, K_LOCK, K_SEL, K_ERR, K_PWR, K_TRIM} kind_t;
    typedef struct {
        int    due;
        kind_t kind;
        int    exp;
        string req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    nchk = 0;
    int    nfail = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int observe(kind_t k);
        case (k)
            K_RD:   return int'(rd_data);
            K_M:    return int'(mult_m);
            K_N:    return int'(div_n);
            K_LOCK: return int'(pll_locked);
            K_SEL:  return int'(clk_sel_synth);
            K_ERR:  return int'(cfg_err);
            K_PWR:  return int'(synth_pwr);
            default: return int'({pump_hi, supply_hi, loop_filt});
        endcase
    endfunction

    // Monitor: compare every item due in this cycle on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    nchk++;
                    if (observe(q[i].kind) != q[i].exp) begin
                        nfail++;
                        $display("FAIL %s kind=%s cycle=%0d actual=%0h expected=%0h",
                                 q[i].req, q[i].kind.name(), cyc,
                                 observe(q[i].kind), q[i].exp);
                    end
                    q.delete(i);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            nfail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic expect_at(int due, kind_t k, int v, string req);
        item_t it;
        it.due = due; it.kind = k; it.exp = v; it.req = req;
        q.push_back(it);
    endtask

    function automatic logic [15:0] mk(bit pwr, bit src, bit pump, bit sup,
                                       logic [3:0] lf, logic [2:0] nc, logic [4:0] mc);
        return {pwr, src, pump, sup, lf, nc, mc};
    endfunction

    function automatic int n_of(logic [2:0] c);
        return (c == 3'd7) ? 1 : int'(c) + 2;
    endfunction

    // Returns the cycle index seen after the write edge
    task automatic write(logic [1:0] a, logic [15:0] d, output int after);
        @(posedge clk); #1;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        after = cyc;
    endtask

    task automatic set_addr(logic [1:0] a, output int now);
        @(posedge clk); #1;
        addr = a;
        now = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check_word(int t, logic [15:0] w, string req);
        expect_at(t, K_RD, int'(w), req);
        expect_at(t, K_M, int'(w[4:0]) + 2, "R4");
        expect_at(t, K_N, n_of(w[7:5]), "R3");
        expect_at(t, K_TRIM, int'(w[13:8]), "R11");
        expect_at(t, K_PWR, int'(w[15]), "R2");
    endtask

    initial begin
        int t;
        logic [15:0] w;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t = cyc;
        expect_at(t, K_RD, 0, "R1");
        expect_at(t, K_LOCK, 0, "R1");
        expect_at(t, K_SEL, 0, "R1");
        expect_at(t, K_ERR, 0, "R1");
        expect_at(t, K_PWR, 0, "R1");

        // Power up with source select already set: select waits for lock
        w = mk(1, 1, 1, 0, 4'b0110, 3'd0, 5'd6);
        write(2'd0, w, t);
        check_word(t, w, "R2");
        expect_at(t, K_LOCK, 0, "R5");
        expect_at(t, K_SEL, 0, "R8");
        expect_at(t + L - 1, K_LOCK, 0, "R5");
        expect_at(t + L - 1, K_SEL, 0, "R8");
        expect_at(t + L, K_LOCK, 1, "R5");
        expect_at(t + L, K_SEL, 1, "R8");
        idle(L + 2);

        // Change only the trim fields: lock kept
        w = mk(1, 1, 0, 1, 4'b1011, 3'd0, 5'd6);
        write(2'd0, w, t);
        check_word(t, w, "R11");
        expect_at(t, K_LOCK, 1, "R7");
        expect_at(t + 3, K_LOCK, 1, "R7");
        expect_at(t + 3, K_SEL, 1, "R8");
        idle(5);

        // New divider code 111 restarts lock
        w = mk(1, 1, 0, 1, 4'b1011, 3'd7, 5'd6);
        write(2'd0, w, t);
        check_word(t, w, "R3");
        expect_at(t, K_LOCK, 0, "R7");
        expect_at(t, K_SEL, 0, "R8");
        expect_at(t + L - 1, K_LOCK, 0, "R7");
        expect_at(t + L, K_LOCK, 1, "R7");
        expect_at(t + L, K_SEL, 1, "R8");
        idle(L + 2);

        // New multiplier code restarts lock
        w = mk(1, 1, 0, 1, 4'b1011, 3'd7, 5'd22);
        write(2'd0, w, t);
        check_word(t, w, "R4");
        expect_at(t, K_LOCK, 0, "R7");
        expect_at(t, K_ERR, 0, "R9");
        expect_at(t + L, K_LOCK, 1, "R7");
        idle(L + 2);

        // Drop source select: reference selected, lock stays
        w = mk(1, 0, 0, 1, 4'b1011, 3'd7, 5'd22);
        write(2'd0, w, t);
        expect_at(t, K_SEL, 0, "R8");
        expect_at(t, K_LOCK, 1, "R8");
        idle(3);

        // Power down, then power up again
        w = mk(0, 1, 0, 1, 4'b1011, 3'd7, 5'd22);
        write(2'd0, w, t);
        expect_at(t, K_LOCK, 0, "R6");
        expect_at(t, K_SEL, 0, "R6");
        expect_at(t, K_PWR, 0, "R6");
        expect_at(t + L + 3, K_LOCK, 0, "R6");
        idle(L + 5);
        w = mk(1, 1, 0, 1, 4'b1011, 3'd7, 5'd22);
        write(2'd0, w, t);
        expect_at(t, K_LOCK, 0, "R6");
        expect_at(t + L - 1, K_LOCK, 0, "R6");
        expect_at(t + L, K_LOCK, 1, "R6");
        expect_at(t + L, K_SEL, 1, "R8");
        idle(L + 2);

        // Illegal multiplier code 23 (M = 25): stored, error sticky
        w = mk(1, 1, 0, 1, 4'b1011, 3'd7, 5'd23);
        write(2'd0, w, t);
        expect_at(t, K_RD, int'(w), "R9");
        expect_at(t, K_M, 25, "R9");
        expect_at(t, K_ERR, 1, "R9");
        idle(2);
        w = mk(1, 1, 0, 1, 4'b1011, 3'd7, 5'd5);
        write(2'd0, w, t);
        expect_at(t, K_ERR, 1, "R9");
        expect_at(t + L, K_LOCK, 1, "R7");
        idle(L + 2);

        // Status read: bit0 lock, bit1 error
        set_addr(2'd1, t);
        expect_at(t, K_RD, 16'h0003, "R10");
        idle(2);

        // Write to status address is ignored
        write(2'd1, 16'h0000, t);
        expect_at(t, K_RD, 16'h0003, "R10");
        expect_at(t, K_LOCK, 1, "R10");
        expect_at(t, K_PWR, 1, "R10");
        idle(2);
        set_addr(2'd0, t);
        expect_at(t, K_RD, int'(w), "R10");
        idle(2);

        // Power down, status shows only the sticky error
        write(2'd0, 16'h0000, t);
        check_word(t, 16'h0000, "R2");
        idle(2);
        set_addr(2'd1, t);
        expect_at(t, K_RD, 16'h0002, "R10");

        idle(4);
        done = 1;
        if (q.size() != 0) begin
            nfail++;
            $display("FAIL scoreboard left %0d unchecked items", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule